// File: doc/BRIEF.md
# Power-Mode System Controller

This block is the operating-mode state machine of a supply-and-bus companion chip that sits beside a host microcontroller. It holds one of five modes: Off, Standby, Normal, Sleep and Overtemp. From that mode it drives five outputs: the regulator enable, the bus transceiver mode, the class of watchdog supervision, the host reset line and the limp-home line. Supply and thermal detector flags, a watchdog reset request, a regulator undervoltage flag and wake-up flags arrive as already-qualified inputs. The host steers the block by writing a 2-bit mode-control value, which is sampled on a single-cycle write strobe.

Every transition takes effect at the clock edge that samples its cause. The outputs are a Moore decode of the mode register, so they change in the cycle that follows that edge. Events are ranked. Battery power-off comes first. Over-temperature comes next. Then come the reset events (watchdog request or regulator undervoltage). A host write is acted on only when none of these is present. The named transitions are:
- power_fail: any mode goes to Off.
- power_up: Off goes to Standby.
- heat_trip: Standby or Normal goes to Overtemp.
- heat_clear: Overtemp goes to Standby.
- reset_event: Standby or Normal goes to Standby.
- host_stby: Normal goes to Standby.
- host_norm: Standby goes to Normal.
- host_sleep: Standby or Normal goes to Sleep.
- wake: Sleep goes to Standby.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, the block is in Off. In Off, `mode_stat` is 0 and `mode_ctl` is 00.
- R2: `bat_poff` high at an edge puts the block in Off from any mode and clears `mode_ctl` to 00. It outranks every other input.
- R3: In Off, `bat_pon` high (with `bat_poff` low) moves the block to Standby. Without `bat_pon` the block stays in Off.
- R4: `ot_act` high in Standby or Normal moves the block to Overtemp and clears `mode_ctl`. It outranks reset events and host writes. In Overtemp, host writes are ignored, and `ot_rel` high returns the block to Standby.
- R5: A write strobe `mc_wr` in Standby or Normal acts on `mc_wdata`. Value 00 selects Standby, and 10 or 11 selects Normal. `mode_ctl` then equals the written value.
- R6: A write of 01 in Standby or Normal enters Sleep, with `mode_ctl` = 01, only if three conditions hold: `intn_hi` is high, at least one `wake_en` bit is set, and no `wake_pend` bit is set. Otherwise the mode and `mode_ctl` stay unchanged.
- R7: In Sleep, host writes are ignored. A `wake_evt` bit whose matching `wake_en` bit is set returns the block to Standby with `mode_ctl` = 00. A wake event on a disabled source has no effect.
- R8: `wd_rst_req` or `v1_uv` in Normal or Standby puts the block in Standby and clears `mode_ctl` to 00. This outranks a host write in the same cycle.
- R9: The outputs per mode follow this table. Transceiver encoding is 0 off, 1 low-power, 2 active. Watchdog encoding is 0 off, 1 timeout, 2 window.
  - Off: `reg_en`=0, `xcvr_mode`=0, `wd_class`=0, `rst_out_n`=0, `limp_n`=1.
  - Overtemp: `reg_en`=0, `xcvr_mode`=0, `wd_class`=0, `rst_out_n`=0, `limp_n`=0.
  - Standby: `reg_en`=1, `xcvr_mode`=1, `wd_class`=1, `rst_out_n`=1, `limp_n`=1.
  - Normal: `reg_en`=1, `xcvr_mode`=2, `wd_class`=2, `rst_out_n`=1, `limp_n`=1.
  - Sleep: `reg_en`=0, `xcvr_mode`=1, `wd_class`=0, `rst_out_n`=0, `limp_n`=1.
- R10: `mode_stat` encodes the mode as follows: Off = 0, Standby = 1, Normal = 2, Sleep = 3, Overtemp = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bat_pon | input | 1 | Battery above power-on level |
| bat_poff | input | 1 | Battery below power-off level |
| ot_act | input | 1 | Temperature above activation level |
| ot_rel | input | 1 | Temperature below release level |
| mc_wr | input | 1 | Single-cycle mode-control write strobe |
| mc_wdata | input | 2 | Mode-control value written by the host |
| intn_hi | input | 1 | Interrupt line is high (no interrupt) |
| wake_en | input | WAKE_N | Per-source wake-up enables |
| wake_pend | input | WAKE_N | Per-source pending wake-ups |
| wake_evt | input | WAKE_N | Per-source wake-up events |
| wd_rst_req | input | 1 | Watchdog reset request |
| v1_uv | input | 1 | Regulator undervoltage |
| reg_en | output | 1 | Regulator enable |
| xcvr_mode | output | 2 | Transceiver mode |
| wd_class | output | 2 | Watchdog supervision class |
| rst_out_n | output | 1 | Host reset line, active low |
| limp_n | output | 1 | Limp-home line, active low |
| mode_stat | output | 3 | Current mode code |
| mode_ctl | output | 2 | Current mode-control value |

## Verification
The hardest case to reach is the Sleep guard. It needs an accepted Sleep request to be told apart from a rejected one for every combination of interrupt level, enable and pending bits, and from both Standby and Normal. A rejected request leaves nothing visible except an unchanged mode and mode-control value.

The bench covers this with a sweep over all four write values and all eight guard combinations, starting from each of the two host-controlled modes. Before each case it drives a power-fail and power-up pulse, which returns the block to a known Standby. Priority collisions are covered by asserting several event flags together with a host write in one cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int MC_W = 2;

    typedef enum logic [2:0] {
        PM_OFF   = 3'd0,
        PM_STBY  = 3'd1,
        PM_NORM  = 3'd2,
        PM_SLEEP = 3'd3,
        PM_OVT   = 3'd4
    } pm_state_e;

    typedef enum logic [1:0] {
        XCV_OFF    = 2'd0,
        XCV_LOWPWR = 2'd1,
        XCV_ACTIVE = 2'd2
    } xcv_mode_e;

    typedef enum logic [1:0] {
        WDC_OFF     = 2'd0,
        WDC_TIMEOUT = 2'd1,
        WDC_WINDOW  = 2'd2
    } wdc_e;

    typedef struct packed {
        logic      reg_en;
        xcv_mode_e xcv;
        wdc_e      wdc;
        logic      rst_n;
        logic      limp_n;
    } pm_out_t;

    localparam logic [MC_W-1:0] MC_STBY  = 2'b00;
    localparam logic [MC_W-1:0] MC_SLEEP = 2'b01;
endpackage

// File: rtl/pmc_sleep_guard.sv
module pmc_sleep_guard #(
    parameter int WAKE_N = 2
) (
    input  logic              intn_hi,
    input  logic [WAKE_N-1:0] wake_en,
    input  logic [WAKE_N-1:0] wake_pend,
    input  logic [WAKE_N-1:0] wake_evt,
    output logic              sleep_ok,
    output logic              wake_hit
);
    logic [WAKE_N-1:0] hit_vec;

    for (genvar i = 0; i < WAKE_N; i++) begin : g_src
        assign hit_vec[i] = wake_evt[i] & wake_en[i];
    end

    always_comb begin
        sleep_ok = intn_hi && (|wake_en) && !(|wake_pend);
        wake_hit = |hit_vec;
    end
endmodule

// File: rtl/pmc_next_state.sv
module pmc_next_state
    import pmc_pkg::*;
(
    input  pm_state_e       cur,
    input  logic [MC_W-1:0] mc_q,
    input  logic            bat_pon,
    input  logic            bat_poff,
    input  logic            ot_act,
    input  logic            ot_rel,
    input  logic            rst_evt,
    input  logic            mc_wr,
    input  logic [MC_W-1:0] mc_wdata,
    input  logic            sleep_ok,
    input  logic            wake_hit,
    output pm_state_e       nxt,
    output logic [MC_W-1:0] mc_nxt
);
    always_comb begin
        nxt    = cur;
        mc_nxt = mc_q;
        if (bat_poff) begin
            nxt    = PM_OFF;
            mc_nxt = MC_STBY;
        end else begin
            unique case (cur)
                PM_OFF: begin
                    mc_nxt = MC_STBY;
                    if (bat_pon) nxt = PM_STBY;
                end
                PM_OVT: begin
                    mc_nxt = MC_STBY;
                    if (ot_rel) nxt = PM_STBY;
                end
                PM_STBY, PM_NORM: begin
                    if (ot_act) begin
                        nxt    = PM_OVT;
                        mc_nxt = MC_STBY;
                    end else if (rst_evt) begin
                        nxt    = PM_STBY;
                        mc_nxt = MC_STBY;
                    end else if (mc_wr) begin
                        if (mc_wdata == MC_STBY) begin
                            nxt    = PM_STBY;
                            mc_nxt = MC_STBY;
                        end else if (mc_wdata == MC_SLEEP) begin
                            if (sleep_ok) begin
                                nxt    = PM_SLEEP;
                                mc_nxt = MC_SLEEP;
                            end
                        end else begin
                            nxt    = PM_NORM;
                            mc_nxt = mc_wdata;
                        end
                    end
                end
                PM_SLEEP: begin
                    if (wake_hit) begin
                        nxt    = PM_STBY;
                        mc_nxt = MC_STBY;
                    end
                end
                default: begin
                    nxt    = PM_OFF;
                    mc_nxt = MC_STBY;
                end
            endcase
        end
    end
endmodule

// File: rtl/pmc_out_decode.sv
module pmc_out_decode
    import pmc_pkg::*;
(
    input  pm_state_e cur,
    output pm_out_t   outs
);
    always_comb begin
        unique case (cur)
            PM_OFF:   outs = '{reg_en: 1'b0, xcv: XCV_OFF,    wdc: WDC_OFF,     rst_n: 1'b0, limp_n: 1'b1};
            PM_OVT:   outs = '{reg_en: 1'b0, xcv: XCV_OFF,    wdc: WDC_OFF,     rst_n: 1'b0, limp_n: 1'b0};
            PM_STBY:  outs = '{reg_en: 1'b1, xcv: XCV_LOWPWR, wdc: WDC_TIMEOUT, rst_n: 1'b1, limp_n: 1'b1};
            PM_NORM:  outs = '{reg_en: 1'b1, xcv: XCV_ACTIVE, wdc: WDC_WINDOW,  rst_n: 1'b1, limp_n: 1'b1};
            PM_SLEEP: outs = '{reg_en: 1'b0, xcv: XCV_LOWPWR, wdc: WDC_OFF,     rst_n: 1'b0, limp_n: 1'b1};
            default:  outs = '{reg_en: 1'b0, xcv: XCV_OFF,    wdc: WDC_OFF,     rst_n: 1'b0, limp_n: 1'b1};
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int WAKE_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bat_pon,
    input  logic              bat_poff,
    input  logic              ot_act,
    input  logic              ot_rel,
    input  logic              mc_wr,
    input  logic [1:0]        mc_wdata,
    input  logic              intn_hi,
    input  logic [WAKE_N-1:0] wake_en,
    input  logic [WAKE_N-1:0] wake_pend,
    input  logic [WAKE_N-1:0] wake_evt,
    input  logic              wd_rst_req,
    input  logic              v1_uv,
    output logic              reg_en,
    output logic [1:0]        xcvr_mode,
    output logic [1:0]        wd_class,
    output logic              rst_out_n,
    output logic              limp_n,
    output logic [2:0]        mode_stat,
    output logic [1:0]        mode_ctl
);
    pm_state_e       state_q, state_d;
    logic [MC_W-1:0] mc_q, mc_d;
    logic            sleep_ok, wake_hit;
    pm_out_t         outs;

    pmc_sleep_guard #(.WAKE_N(WAKE_N)) u_guard (
        .intn_hi   (intn_hi),
        .wake_en   (wake_en),
        .wake_pend (wake_pend),
        .wake_evt  (wake_evt),
        .sleep_ok  (sleep_ok),
        .wake_hit  (wake_hit)
    );

    pmc_next_state u_next (
        .cur      (state_q),
        .mc_q     (mc_q),
        .bat_pon  (bat_pon),
        .bat_poff (bat_poff),
        .ot_act   (ot_act),
        .ot_rel   (ot_rel),
        .rst_evt  (wd_rst_req | v1_uv),
        .mc_wr    (mc_wr),
        .mc_wdata (mc_wdata),
        .sleep_ok (sleep_ok),
        .wake_hit (wake_hit),
        .nxt      (state_d),
        .mc_nxt   (mc_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_OFF;
            mc_q    <= MC_STBY;
        end else begin
            state_q <= state_d;
            mc_q    <= mc_d;
        end
    end

    pmc_out_decode u_dec (
        .cur  (state_q),
        .outs (outs)
    );

    always_comb begin
        reg_en    = outs.reg_en;
        xcvr_mode = outs.xcv;
        wd_class  = outs.wdc;
        rst_out_n = outs.rst_n;
        limp_n    = outs.limp_n;
        mode_stat = state_q;
        mode_ctl  = mc_q;
    end

    a_r2_poff_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        bat_poff |=> (mode_stat == 3'd0 && mode_ctl == 2'b00));

    a_r6_sleep_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 3'd3 && $past(mode_stat) != 3'd3)
            |-> $past(intn_hi && (|wake_en) && !(|wake_pend)));

    a_r8_reset_event: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_stat == 3'd2) && !bat_poff && !ot_act && (wd_rst_req || v1_uv))
            |=> (mode_stat == 3'd1 && mode_ctl == 2'b00));

    a_r9_ovt_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 3'd4) |-> (!reg_en && !limp_n && wd_class == 2'd0 && xcvr_mode == 2'd0));

    a_r9_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 3'd3) |-> (!reg_en && !rst_out_n && wd_class == 2'd0));

    a_r4_ovt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 3'd4 && !bat_poff && !ot_rel) |=> (mode_stat == 3'd4));
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bat_pon = 0, bat_poff = 0, ot_act = 0, ot_rel = 0;
    logic       mc_wr = 0;
    logic [1:0] mc_wdata = 0;
    logic       intn_hi = 0;
    logic [1:0] wake_en = 0, wake_pend = 0, wake_evt = 0;
    logic       wd_rst_req = 0, v1_uv = 0;
    logic       reg_en, rst_out_n, limp_n;
    logic [1:0] xcvr_mode, wd_class, mode_ctl;
    logic [2:0] mode_stat;
    int         n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    pwr_mode_ctrl #(.WAKE_N(2)) dut (
        .clk(clk), .rst_n(rst_n), .bat_pon(bat_pon), .bat_poff(bat_poff),
        .ot_act(ot_act), .ot_rel(ot_rel), .mc_wr(mc_wr), .mc_wdata(mc_wdata),
        .intn_hi(intn_hi), .wake_en(wake_en), .wake_pend(wake_pend),
        .wake_evt(wake_evt), .wd_rst_req(wd_rst_req), .v1_uv(v1_uv),
        .reg_en(reg_en), .xcvr_mode(xcvr_mode), .wd_class(wd_class),
        .rst_out_n(rst_out_n), .limp_n(limp_n), .mode_stat(mode_stat),
        .mode_ctl(mode_ctl)
    );

    // expected {reg_en, xcvr, wd, rst_n, limp_n} per mode code (R9)
    function automatic logic [6:0] exp_outs(input int m);
        case (m)
            0: return {1'b0, 2'd0, 2'd0, 1'b0, 1'b1};
            1: return {1'b1, 2'd1, 2'd1, 1'b1, 1'b1};
            2: return {1'b1, 2'd2, 2'd2, 1'b1, 1'b1};
            3: return {1'b0, 2'd1, 2'd0, 1'b0, 1'b1};
            default: return {1'b0, 2'd0, 2'd0, 1'b0, 1'b0};
        endcase
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic chk_mode(input string tag, input int m, input int mc);
        chk({tag, " R10 mode_stat"}, mode_stat, m);
        chk({tag, " mode_ctl"}, mode_ctl, mc);
        chk({tag, " R9 outputs"}, {reg_en, xcvr_mode, wd_class, rst_out_n, limp_n}, exp_outs(m));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_stby();
        bat_poff = 1; step(); bat_poff = 0;
        bat_pon = 1;  step(); bat_pon = 0;
    endtask

    task automatic host_wr(input logic [1:0] v);
        mc_wr = 1; mc_wdata = v; step(); mc_wr = 0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got hang exp finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk_mode("R1 in reset", 0, 0);
        rst_n = 1;
        step();
        chk_mode("R1 after release", 0, 0);
        // R3: stay Off without pon, write ignored
        host_wr(2'b10);
        chk_mode("R3 no pon", 0, 0);
        bat_pon = 1; step(); bat_pon = 0;
        chk_mode("R3 power up", 1, 0);

        // R5/R6 sweep from Standby and Normal
        for (int from = 1; from <= 2; from++) begin
            for (int w = 0; w < 4; w++) begin
                for (int g = 0; g < 8; g++) begin
                    int em, emc;
                    bit ok;
                    go_stby();
                    if (from == 2) host_wr(2'b10);
                    intn_hi   = g[0];
                    wake_en   = g[1] ? 2'b10 : 2'b00;
                    wake_pend = g[2] ? 2'b01 : 2'b00;
                    host_wr(w[1:0]);
                    ok = g[0] && g[1] && !g[2];
                    if (w == 0)      begin em = 1; emc = 0; end
                    else if (w == 1) begin em = ok ? 3 : from; emc = ok ? 1 : (from == 2 ? 2 : 0); end
                    else             begin em = 2; emc = w; end
                    chk_mode((w == 1) ? "R6 sleep req" : "R5 host write", em, emc);
                    intn_hi = 0; wake_en = 0; wake_pend = 0;
                end
            end
        end

        // R7: sleep, writes ignored, disabled wake ignored, enabled wake exits
        go_stby();
        intn_hi = 1; wake_en = 2'b01;
        host_wr(2'b01);
        chk_mode("R7 in sleep", 3, 1);
        host_wr(2'b10);
        chk_mode("R7 write ignored", 3, 1);
        wake_evt = 2'b10; step(); wake_evt = 0;
        chk_mode("R7 disabled wake", 3, 1);
        wake_evt = 2'b01; step(); wake_evt = 0;
        chk_mode("R7 wake exit", 1, 0);
        intn_hi = 0; wake_en = 0;

        // R8: reset events beat host write
        host_wr(2'b11);
        chk_mode("R8 setup normal", 2, 3);
        wd_rst_req = 1; mc_wr = 1; mc_wdata = 2'b10; step();
        wd_rst_req = 0; mc_wr = 0;
        chk_mode("R8 wd reset", 1, 0);
        host_wr(2'b10);
        v1_uv = 1; step(); v1_uv = 0;
        chk_mode("R8 undervoltage", 1, 0);

        // R4: over-temperature beats reset event and write
        host_wr(2'b10);
        ot_act = 1; wd_rst_req = 1; mc_wr = 1; mc_wdata = 2'b11; step();
        ot_act = 0; wd_rst_req = 0; mc_wr = 0;
        chk_mode("R4 heat trip", 4, 0);
        host_wr(2'b10);
        chk_mode("R4 write ignored", 4, 0);
        ot_rel = 1; step(); ot_rel = 0;
        chk_mode("R4 heat clear", 1, 0);
        ot_act = 1; step(); ot_act = 0;
        chk_mode("R4 trip from stby", 4, 0);

        // R2: power-off beats everything, from several modes
        bat_poff = 1; ot_rel = 1; step(); bat_poff = 0; ot_rel = 0;
        chk_mode("R2 from ovt", 0, 0);
        bat_pon = 1; step(); bat_pon = 0;
        host_wr(2'b11);
        bat_poff = 1; ot_act = 1; v1_uv = 1; mc_wr = 1; mc_wdata = 2'b00; step();
        bat_poff = 0; ot_act = 0; v1_uv = 0; mc_wr = 0;
        chk_mode("R2 from normal", 0, 0);
        bat_pon = 1; step(); bat_pon = 0;
        intn_hi = 1; wake_en = 2'b11;
        host_wr(2'b01);
        bat_poff = 1; wake_evt = 2'b11; step(); bat_poff = 0; wake_evt = 0;
        chk_mode("R2 from sleep", 0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule